// File: doc/BRIEF.md
# DDR Burst Interruption Rule Monitor

This block watches a decoded DDR SDRAM command stream, one command per clock. It keeps track of the read or write burst in flight and raises a sticky flag whenever a command breaks one of the burst-interruption rules. It also produces the column address that the memory would use on every write data beat, so a surrounding testbench can compare the address on the data path against the address the monitor computes.

The monitor models bursts as a beat stream that advances one beat per clock. The burst length is picked per command from a 2-bit select and is latched when the command is accepted. The CAS latency is given in half-clock units. The monitor rounds it up to whole clocks to form the minimum spacing between a burst terminate and the next write. Electrical timing, strobe capture, refresh and bank state are not modelled.

Top module: `ddr_burst_rule_mon`

## Requirements
- R1: Command codes are 0 idle, 1 read, 2 read with autoprecharge, 3 write, 4 burst terminate, and 5 to 7 act as idle. While reset is held, and in the first cycle after it, `wr_beat_valid`, `burst_active` and all of `viol_flags` are 0.
- R2: A write accepted at a clock edge makes `wr_beat_valid` high from the next cycle for exactly BL cycles. Beat i carries the address whose bits above the low log2(BL) bits equal the command address, and whose low bits are (address + i) mod BL, so the sequence wraps inside the aligned block of size BL.
- R3: `bl_sel` encodes BL as 0 → 2, 1 → 4, 2 → 8 and 3 → 8. It is sampled together with each read or write command and holds for that whole burst.
- R4: A write accepted while a write burst runs, including one in the very next clock, drops the remaining beats and restarts the address sequence at the new address for a full BL. It raises no flag.
- R5: A write accepted while a plain read burst is active sets `viol_flags[0]`. The read burst ends and the write beats start as in R2.
- R6: A burst terminate accepted during a plain read ends the read at once. A write accepted n clocks after it sets `viol_flags[1]` when n < ceil(`cl_half`/2), with `cl_half` taken at the terminate. For example, `cl_half` = 5 requires n ≥ 3.
- R7: A write accepted while a read-with-autoprecharge burst is active sets `viol_flags[2]`. A burst terminate neither ends such a burst nor starts the spacing timer.
- R8: A burst terminate accepted while no read is active is ignored. A write burst in flight keeps its beats and addresses, and a write that follows raises no spacing flag.
- R9: Each flag stays set until `clr_flags` is high at a clock edge. A violation detected at the same edge as a clear still leaves its own bit set.
- R10: A read accepted at an edge keeps `burst_active` high for exactly BL cycles from the next cycle. It also drops any write beats, and a new read restarts the read burst. `burst_active` is high whenever write beats or a read burst are in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_flags | input | 1 | Synchronous clear of all violation flags |
| cmd_code | input | 3 | Decoded command for this clock |
| col_addr | input | COL_W | Column address that comes with the command |
| bl_sel | input | 2 | Burst length select |
| cl_half | input | CLH_W | CAS latency in half clocks |
| wr_beat_valid | output | 1 | A write data beat is expected this cycle |
| wr_beat_addr | output | COL_W | Column address of the current write beat |
| burst_active | output | 1 | A read or write burst is in progress |
| viol_flags | output | 3 | Sticky flags: [0] unterminated read, [1] terminate-to-write spacing, [2] autoprecharge read |

## Verification
Directed sequences separate the outcomes that look alike at the ports. Back-to-back and mid-burst writes must restart the address without a flag. A write straight into a read must set only the unterminated flag. Writes one, two and three clocks after a terminate, with a CAS latency of 2.5, mark the exact rounding boundary. A terminate during an autoprecharge read or during a write must change nothing. Start addresses near the top of each aligned block, under every burst-length code, expose wrap errors. A long seeded random stream mixes all commands, latencies and clears, which reaches overlaps such as a new read inside the spacing window followed by a write.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE = 3'd0,
      CMD_RD   = 3'd1,
      CMD_RDA  = 3'd2,
      CMD_WR   = 3'd3,
      CMD_TERM = 3'd4
   } mon_cmd_e;

   localparam int FLG_NOTERM = 0;
   localparam int FLG_GAP    = 1;
   localparam int FLG_RDAP   = 2;
   localparam int FLG_COUNT  = 3;

endpackage

// File: rtl/burst_track.sv
module burst_track #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [CNT_W-1:0] start_mask,
   output logic             active,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
         mask_q <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt_q  <= '0;
         mask_q <= start_mask;
      end else if (stop) begin
         active <= 1'b0;
      end else if (active) begin
         if (cnt_q == mask_q) active <= 1'b0;
         else                 cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign last = active && (cnt_q == mask_q);

   a_r2_start_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (active && cnt_q == '0));

   a_r10_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start && !stop) |=> !active);

   a_r10_runs_until_last: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last && !start && !stop) |=> active);

endmodule

// File: rtl/wr_addr_seq.sv
module wr_addr_seq #(
   parameter int COL_W = 10,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [COL_W-1:0] load_addr,
   input  logic [CNT_W-1:0] load_mask,
   input  logic             advance,
   output logic [COL_W-1:0] addr
);

   localparam int HI_W = COL_W - CNT_W;

   logic [CNT_W-1:0] mask_q;
   logic [CNT_W-1:0] low_q;
   logic [HI_W-1:0]  high_q;
   logic [CNT_W-1:0] low_step;

   always_comb begin
      low_step = (low_q & ~mask_q) | ((low_q + CNT_W'(1)) & mask_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         low_q  <= '0;
         high_q <= '0;
      end else if (load) begin
         mask_q <= load_mask;
         low_q  <= load_addr[CNT_W-1:0];
         high_q <= load_addr[COL_W-1:CNT_W];
      end else if (advance) begin
         low_q  <= low_step;
      end
   end

   assign addr = {high_q, low_q};

   a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr == $past(load_addr)));

   a_r2_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> ((addr[COL_W-1:CNT_W] == $past(addr[COL_W-1:CNT_W]))
                              && ((addr[CNT_W-1:0] & ~mask_q) == ($past(addr[CNT_W-1:0]) & ~mask_q))));

endmodule

// File: rtl/term_gap_timer.sv
module term_gap_timer #(
   parameter int T_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [T_W-1:0] load_val,
   output logic [T_W-1:0] remain
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= load_val;
      else if (remain != '0)   remain <= remain - T_W'(1);
   end

   a_r6_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (remain == $past(load_val)));

   a_r6_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (remain != '0 && !load) |=> (remain == $past(remain) - T_W'(1)));

   a_r6_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (remain == '0 && !load) |=> (remain == '0));

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[g] <= 1'b0;
         else        flags[g] <= (flags[g] & ~clr) | set[g];
      end

      a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[g] && !clr) |=> flags[g]);

      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[g] |=> flags[g]);

      a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !set[g]) |=> !flags[g]);
   end

endmodule

// File: rtl/ddr_burst_rule_mon.sv
module ddr_burst_rule_mon
   import ddr_mon_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int CLH_W  = 3,
   parameter int MAX_BL = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_flags,
   input  logic [2:0]           cmd_code,
   input  logic [COL_W-1:0]     col_addr,
   input  logic [1:0]           bl_sel,
   input  logic [CLH_W-1:0]     cl_half,
   output logic                 wr_beat_valid,
   output logic [COL_W-1:0]     wr_beat_addr,
   output logic                 burst_active,
   output logic [FLG_COUNT-1:0] viol_flags
);

   localparam int CNT_W = $clog2(MAX_BL);

   if (MAX_BL != 8) begin : g_bad_bl
      $error("MAX_BL must be 8 to cover every burst-length code");
   end
   if (COL_W <= CNT_W) begin : g_bad_col
      $error("COL_W must exceed log2(MAX_BL)");
   end
   if (CLH_W < 2) begin : g_bad_cl
      $error("CLH_W must be at least 2");
   end

   logic             is_wr, is_rd, is_rda, is_term;
   logic             rd_active, rd_last, rd_ap_q;
   logic             wr_active, wr_last;
   logic             rd_plain, gap_load;
   logic [CNT_W-1:0] sel_mask;
   logic [CLH_W:0]   gap_clk;
   logic [CLH_W-1:0] gap_val, gap_remain;
   logic [FLG_COUNT-1:0] viol_set;

   always_comb begin
      is_wr   = (cmd_code == CMD_WR);
      is_rda  = (cmd_code == CMD_RDA);
      is_rd   = (cmd_code == CMD_RD) || is_rda;
      is_term = (cmd_code == CMD_TERM);
   end

   always_comb begin
      case (bl_sel)
         2'd0:    sel_mask = CNT_W'(1);
         2'd1:    sel_mask = CNT_W'(3);
         default: sel_mask = CNT_W'(7);
      endcase
   end

   always_comb begin
      gap_clk = ({1'b0, cl_half} + (CLH_W+1)'(1)) >> 1;
      gap_val = (gap_clk == '0) ? '0 : CLH_W'(gap_clk - (CLH_W+1)'(1));
   end

   assign rd_plain = rd_active && !rd_ap_q;
   assign gap_load = is_term && rd_plain;

   always_comb begin
      viol_set               = '0;
      viol_set[FLG_NOTERM]   = is_wr && rd_plain;
      viol_set[FLG_RDAP]     = is_wr && rd_active && rd_ap_q;
      viol_set[FLG_GAP]      = is_wr && (gap_remain != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_ap_q <= 1'b0;
      else if (is_rd) rd_ap_q <= is_rda;
   end

   burst_track #(.CNT_W(CNT_W)) u_wr_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (is_wr),
      .stop       (is_rd),
      .start_mask (sel_mask),
      .active     (wr_active),
      .last       (wr_last)
   );

   burst_track #(.CNT_W(CNT_W)) u_rd_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (is_rd),
      .stop       (is_wr || gap_load),
      .start_mask (sel_mask),
      .active     (rd_active),
      .last       (rd_last)
   );

   wr_addr_seq #(.COL_W(COL_W), .CNT_W(CNT_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (is_wr),
      .load_addr (col_addr),
      .load_mask (sel_mask),
      .advance   (wr_active),
      .addr      (wr_beat_addr)
   );

   term_gap_timer #(.T_W(CLH_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .remain   (gap_remain)
   );

   sticky_flags #(.N(FLG_COUNT)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_flags),
      .set   (viol_set),
      .flags (viol_flags)
   );

   assign wr_beat_valid = wr_active;
   assign burst_active  = wr_active || rd_active;

   a_r5_noterm_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && rd_active && !rd_ap_q) |=> viol_flags[FLG_NOTERM]);

   a_r7_rdap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && rd_active && rd_ap_q) |=> viol_flags[FLG_RDAP]);

   a_r7_term_keeps_rdap: assert property (@(posedge clk) disable iff (!rst_n)
      (is_term && rd_active && rd_ap_q && !rd_last) |=> rd_active);

   a_r6_term_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
      (is_term && rd_active && !rd_ap_q) |=> !rd_active);

   a_r8_term_no_timer: assert property (@(posedge clk) disable iff (!rst_n)
      (is_term && !rd_active && gap_remain == '0) |=> (gap_remain == '0));

   a_r8_term_keeps_write: assert property (@(posedge clk) disable iff (!rst_n)
      (is_term && wr_active && !wr_last) |=> wr_active);

   a_r10_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_active && rd_active));

   a_r4_no_flag_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && wr_active && gap_remain == '0 && !clr_flags
       && viol_flags == '0) |=> (viol_flags == '0));

endmodule

// File: tb/tb_ddr_burst_rule_mon.sv
`timescale 1ns/1ps
module tb_ddr_burst_rule_mon;

   localparam int COL_W = 10;
   localparam int CLH_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr_flags = 1'b0;
   logic [2:0]       cmd_code = 3'd0;
   logic [COL_W-1:0] col_addr = '0;
   logic [1:0]       bl_sel = 2'd1;
   logic [CLH_W-1:0] cl_half = 3'd5;
   logic             wr_beat_valid;
   logic [COL_W-1:0] wr_beat_addr;
   logic             burst_active;
   logic [2:0]       viol_flags;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   ddr_burst_rule_mon #(.COL_W(COL_W), .CLH_W(CLH_W), .MAX_BL(8)) dut (
      .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags), .cmd_code(cmd_code),
      .col_addr(col_addr), .bl_sel(bl_sel), .cl_half(cl_half),
      .wr_beat_valid(wr_beat_valid), .wr_beat_addr(wr_beat_addr),
      .burst_active(burst_active), .viol_flags(viol_flags)
   );

   always #2.5 clk = ~clk;

   // reference state, derived from the requirements
   bit         m_wv, m_rv, m_rap;
   bit [9:0]   m_wbase;
   bit [2:0]   m_wcnt, m_wmask, m_rcnt, m_rmask, m_tmr;
   bit [2:0]   m_flags;

   function automatic bit [2:0] bl_mask(input bit [1:0] s);
      return (s == 2'd0) ? 3'd1 : (s == 2'd1) ? 3'd3 : 3'd7;
   endfunction

   function automatic bit [9:0] exp_addr();
      return {m_wbase[9:3], (m_wbase[2:0] & ~m_wmask) | ((m_wbase[2:0] + m_wcnt) & m_wmask)};
   endfunction

   task automatic model_next(input bit [2:0] c, input bit [9:0] a, input bit [1:0] bl,
                             input bit [2:0] cl, input bit clr);
      bit wr, rd, term, ap;
      bit [2:0] nf;
      bit [3:0] gap;
      wr = (c == 3'd3); rd = (c == 3'd1) || (c == 3'd2); ap = (c == 3'd2); term = (c == 3'd4);
      nf = 3'b000;
      if (wr && m_rv && !m_rap) nf[0] = 1'b1;
      if (wr && m_rv && m_rap)  nf[2] = 1'b1;
      if (wr && m_tmr != 0)     nf[1] = 1'b1;
      gap = (4'(cl) + 4'd1) >> 1;
      if (term && m_rv && !m_rap) m_tmr = (gap == 0) ? 3'd0 : 3'(gap - 4'd1);
      else if (m_tmr != 0)        m_tmr = m_tmr - 3'd1;
      if (wr) begin
         m_wv = 1'b1; m_wbase = a; m_wcnt = 3'd0; m_wmask = bl_mask(bl);
      end else if (rd) m_wv = 1'b0;
      else if (m_wv) begin
         if (m_wcnt == m_wmask) m_wv = 1'b0; else m_wcnt = m_wcnt + 3'd1;
      end
      if (rd) begin
         m_rv = 1'b1; m_rap = ap; m_rcnt = 3'd0; m_rmask = bl_mask(bl);
      end else if (wr) m_rv = 1'b0;
      else if (term && m_rv && !m_rap) m_rv = 1'b0;
      else if (m_rv) begin
         if (m_rcnt == m_rmask) m_rv = 1'b0; else m_rcnt = m_rcnt + 3'd1;
      end
      m_flags = (clr ? 3'b000 : m_flags) | nf;
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check(tag, "wr_beat_valid", int'(wr_beat_valid), int'(m_wv));
      if (m_wv) check(tag, "wr_beat_addr", int'(wr_beat_addr), int'(exp_addr()));
      check(tag, "burst_active", int'(burst_active), int'(m_wv | m_rv));
      check(tag, "viol_flags", int'(viol_flags), int'(m_flags));
   endtask

   // drive one command just after a falling edge, check after the next falling edge
   task automatic step(input bit [2:0] c, input bit [9:0] a, input bit [1:0] bl,
                       input bit [2:0] cl, input bit clr, input string tag);
      cmd_code = c; col_addr = a; bl_sel = bl; cl_half = cl; clr_flags = clr;
      model_next(c, a, bl, cl, clr);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(3'd0, 10'd0, 2'd1, 3'd5, 1'b0, tag);
   endtask

   task automatic clear(input string tag);
      step(3'd0, 10'd0, 2'd1, 3'd5, 1'b1, tag);
   endtask

   initial begin
      #(200000.0 * 5.0);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1", "reset valid", int'(wr_beat_valid), 0);
      check("R1", "reset active", int'(burst_active), 0);
      check("R1", "reset flags", int'(viol_flags), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R2: burst of 4 wrapping inside its block
      step(3'd3, 10'h20D, 2'd1, 3'd5, 1'b0, "R2");
      idle(5, "R2");
      // R3: each burst-length code
      step(3'd3, 10'h005, 2'd0, 3'd5, 1'b0, "R3");
      idle(3, "R3");
      step(3'd3, 10'h113, 2'd2, 3'd5, 1'b0, "R3");
      idle(9, "R3");
      step(3'd3, 10'h0FE, 2'd3, 3'd5, 1'b0, "R3");
      step(3'd0, 10'h000, 2'd0, 3'd5, 1'b0, "R3");
      idle(8, "R3");
      // R4: mid-burst and back-to-back write restarts
      step(3'd3, 10'h040, 2'd1, 3'd5, 1'b0, "R4");
      step(3'd0, 10'h000, 2'd1, 3'd5, 1'b0, "R4");
      step(3'd3, 10'h087, 2'd1, 3'd5, 1'b0, "R4");
      step(3'd3, 10'h09A, 2'd2, 3'd5, 1'b0, "R4");
      idle(9, "R4");
      // R5: write into a plain read
      step(3'd1, 10'h010, 2'd1, 3'd5, 1'b0, "R5");
      step(3'd3, 10'h022, 2'd1, 3'd5, 1'b0, "R5");
      idle(5, "R5");
      clear("R9");
      // R6: terminate then write 1, 2, 3 clocks later at CL 2.5
      step(3'd1, 10'h000, 2'd2, 3'd5, 1'b0, "R6");
      step(3'd4, 10'h000, 2'd1, 3'd5, 1'b0, "R6");
      step(3'd3, 10'h030, 2'd1, 3'd5, 1'b0, "R6");
      idle(5, "R6");
      clear("R6");
      step(3'd1, 10'h000, 2'd2, 3'd5, 1'b0, "R6");
      step(3'd4, 10'h000, 2'd1, 3'd5, 1'b0, "R6");
      step(3'd0, 10'h000, 2'd1, 3'd5, 1'b0, "R6");
      step(3'd3, 10'h031, 2'd1, 3'd5, 1'b0, "R6");
      idle(5, "R6");
      clear("R6");
      step(3'd1, 10'h000, 2'd2, 3'd5, 1'b0, "R6");
      step(3'd4, 10'h000, 2'd1, 3'd5, 1'b0, "R6");
      idle(2, "R6");
      step(3'd3, 10'h032, 2'd1, 3'd5, 1'b0, "R6");
      idle(5, "R6");
      // R6: CL 4 half-cycles needs 2 clocks
      step(3'd1, 10'h000, 2'd1, 3'd4, 1'b0, "R6");
      step(3'd4, 10'h000, 2'd1, 3'd4, 1'b0, "R6");
      step(3'd0, 10'h000, 2'd1, 3'd4, 1'b0, "R6");
      step(3'd3, 10'h033, 2'd1, 3'd4, 1'b0, "R6");
      idle(5, "R6");
      // R7: terminate does not end an autoprecharge read; write flags it
      step(3'd2, 10'h000, 2'd2, 3'd5, 1'b0, "R7");
      step(3'd4, 10'h000, 2'd1, 3'd5, 1'b0, "R7");
      step(3'd0, 10'h000, 2'd1, 3'd5, 1'b0, "R7");
      step(3'd3, 10'h044, 2'd1, 3'd5, 1'b0, "R7");
      idle(5, "R7");
      clear("R7");
      // R8: terminate during a write and when idle is ignored
      step(3'd3, 10'h055, 2'd2, 3'd5, 1'b0, "R8");
      step(3'd4, 10'h000, 2'd1, 3'd7, 1'b0, "R8");
      step(3'd0, 10'h000, 2'd1, 3'd7, 1'b0, "R8");
      idle(7, "R8");
      step(3'd4, 10'h000, 2'd1, 3'd7, 1'b0, "R8");
      step(3'd3, 10'h066, 2'd1, 3'd7, 1'b0, "R8");
      idle(5, "R8");
      // R9: clear and a new violation in the same edge
      step(3'd1, 10'h000, 2'd1, 3'd5, 1'b0, "R9");
      step(3'd3, 10'h070, 2'd1, 3'd5, 1'b0, "R9");
      step(3'd2, 10'h000, 2'd1, 3'd5, 1'b0, "R9");
      step(3'd3, 10'h071, 2'd1, 3'd5, 1'b1, "R9");
      idle(3, "R9");
      clear("R9");
      // R10: read stops write beats, read length, read restart
      step(3'd3, 10'h080, 2'd2, 3'd5, 1'b0, "R10");
      step(3'd0, 10'h000, 2'd2, 3'd5, 1'b0, "R10");
      step(3'd1, 10'h000, 2'd0, 3'd5, 1'b0, "R10");
      step(3'd0, 10'h000, 2'd0, 3'd5, 1'b0, "R10");
      step(3'd1, 10'h000, 2'd2, 3'd5, 1'b0, "R10");
      idle(10, "R10");

      // seeded random mix
      begin
         bit [2:0] cl;
         cl = 3'd5;
         for (int i = 0; i < 4000; i++) begin
            int r;
            bit [2:0] c;
            if (i % 60 == 0) cl = 3'($urandom % 8);
            r = int'($urandom % 16);
            if (r < 4)       c = 3'd0;
            else if (r < 7)  c = 3'd3;
            else if (r < 9)  c = 3'd1;
            else if (r < 10) c = 3'd2;
            else if (r < 13) c = 3'd4;
            else             c = 3'(5 + ($urandom % 3));
            step(c, 10'($urandom), 2'($urandom), cl, ($urandom % 24) == 0, "rand");
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule